// File: doc/BRIEF.md
# Core Store Read/Restore Sequencer

This block sequences one complete access to a coincident-current magnetic core store. A CPU read call, together with an address held in two address registers (M and N), starts a read: the sequencer closes the decode switches at both ends of the chosen X line and the chosen Y line and turns on their control drivers. After a setup window it enables the read drive currents and gates the addressed group of sense windings to the amplifiers. In the last drive cycle it strobes the detector latches, and it then pulses data-ready.

Core readout destroys the stored word, so every read must be followed by a restore. The CPU issues a write call without touching the address registers. The sequencer drives the same two lines again with the current reversed. The Y line is set up first, then the X line. During the X write current the inhibit lines carry the complement of the data to store. That data is the latched read word, unless the CPU offered replacement data with its write call. A read call that arrives before the restore has finished is held off by `busy` and is dropped, not queued.

Top module: `core_rr_seq`

## Requirements
- R1: After reset, `busy`, `data_ready`, `sa_strobe`, every switch, control-driver and current enable, `sa_gate`, `inhibit` and `rd_data` are all 0.
- R2: A read call is accepted only in idle, and only when `use_main` is 1 and `m_addr[0]` is 0. Any other read call leaves the block idle.
- R3: On the edge that accepts a read, the source and sink read switches for X line `n_addr` and Y line `m_addr[M_W-1:1]` turn on as one-hot vectors, together with the X and Y read control drivers. The read currents follow exactly SETUP_CYC cycles later and last DRIVE_CYC cycles.
- R4: While the read currents are on, `sa_gate` is one-hot at group `n_addr[N_W-1 -: SG_W]`. `sa_strobe` is high only in the last read drive cycle. The detector latches OR in only the `sense_in` slice of the gated group (bits `g*WORD_W +: WORD_W`), and only on that strobe.
- R5: The detector latches, seen on `rd_data`, are 0 in the first cycle of every read.
- R6: `data_ready` is a single-cycle pulse in the cycle after the read currents end. `rd_data` then holds the captured word and `busy` stays high while the block waits for the write call.
- R7: A write call is accepted only while the block waits after a read, under the same `use_main`/`m_addr[0]` qualification. A write call in idle, or one with `m_addr[0]` = 1, is ignored.
- R8: The restore first turns on the Y write switches and the Y write control driver for SETUP_CYC cycles. Next the Y write current and the X write switches with the X write control driver are on for SETUP_CYC cycles. Then the X write current is on for DRIVE_CYC cycles. Both lines are the ones captured at the read.
- R9: Read-polarity and write-polarity enables are never on together. Every current enable is preceded by its line's switch enables in the previous cycle.
- R10: While the X write current is on, `inhibit` equals the bitwise complement of the restore word. That word is `wr_data` if `wr_data_valid` is 1 with the accepted write call, and otherwise the latched read word.
- R11: `busy` is high from the accepted read call until the last X write current cycle has passed. Read calls made while busy start nothing, before or after the restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Storage clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| read_call | input | 1 | CPU read request, sampled each edge |
| write_call | input | 1 | CPU restore/write request |
| use_main | input | 1 | Main store selected qualifier |
| m_addr | input | M_W | M address register (bit 0 is the go bit, upper bits select the Y line) |
| n_addr | input | N_W | N address register (selects the X line, upper bits select the sense group) |
| wr_data_valid | input | 1 | Replacement data offered with the write call |
| wr_data | input | WORD_W | Replacement data word |
| sense_in | input | GROUPS*WORD_W | Sense amplifier outputs, one slice per winding group |
| busy | output | 1 | Access in progress |
| data_ready | output | 1 | Read word available (one-cycle pulse) |
| rd_data | output | WORD_W | Detector latch contents |
| x_src_rd | output | X_N | X source-end switches, read polarity |
| x_snk_rd | output | X_N | X sink-end switches, read polarity |
| x_src_wr | output | X_N | X source-end switches, write polarity |
| x_snk_wr | output | X_N | X sink-end switches, write polarity |
| y_src_rd | output | Y_N | Y source-end switches, read polarity |
| y_snk_rd | output | Y_N | Y sink-end switches, read polarity |
| y_src_wr | output | Y_N | Y source-end switches, write polarity |
| y_snk_wr | output | Y_N | Y sink-end switches, write polarity |
| x_ctl_rd | output | 1 | X read control drivers |
| x_ctl_wr | output | 1 | X write control drivers |
| y_ctl_rd | output | 1 | Y read control drivers |
| y_ctl_wr | output | 1 | Y write control drivers |
| x_cur_rd | output | 1 | X read current source/sink |
| x_cur_wr | output | 1 | X write current source/sink |
| y_cur_rd | output | 1 | Y read current source/sink |
| y_cur_wr | output | 1 | Y write current source/sink |
| sa_gate | output | GROUPS | Sense winding group gates |
| sa_strobe | output | 1 | Detector latch strobe |
| inhibit | output | WORD_W | Inhibit drivers during the write current |

## Verification
The bench builds the block with N_W=3, M_W=3, SG_W=1, WORD_W=4, SETUP_CYC=2 and DRIVE_CYC=3. This gives eight X lines, four Y lines and two sense groups, small enough that a behavioural core array of 32 words can sit beside the block. Because the setup and drive windows differ in length, an exchanged counter load moves every phase edge the bench samples. While the read current flows, the unselected sense group always reads all ones, so a gating fault corrupts `rd_data`. The vectors cover both groups, both corner X lines and both restore sources.

// File: rtl/core_rr_pkg.sv
package core_rr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_SW   = 3'd1,
        ST_RD_DRV  = 3'd2,
        ST_RD_END  = 3'd3,
        ST_WAIT_WR = 3'd4,
        ST_WY_SW   = 3'd5,
        ST_WX_SW   = 3'd6,
        ST_W_DRV   = 3'd7
    } seq_st_e;

endpackage

// File: rtl/core_rr_dec.sv
module core_rr_dec #(
    parameter int IDX_W = 3,
    localparam int OUT_N = 2 ** IDX_W
) (
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [OUT_N-1:0] oh
);

    for (genvar i = 0; i < OUT_N; i++) begin : g_line
        assign oh[i] = en && (idx == IDX_W'(i));
    end

endmodule

// File: rtl/core_rr_fsm.sv
module core_rr_fsm
    import core_rr_pkg::*;
#(
    parameter int X_W       = 6,
    parameter int Y_W       = 6,
    parameter int G_W       = 2,
    parameter int SETUP_CYC = 2,
    parameter int DRIVE_CYC = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           read_call,
    input  logic           write_call,
    input  logic           go,
    input  logic [X_W-1:0] x_in,
    input  logic [Y_W-1:0] y_in,
    input  logic [G_W-1:0] g_in,
    output logic [X_W-1:0] x_idx,
    output logic [Y_W-1:0] y_idx,
    output logic [G_W-1:0] g_idx,
    output logic           rd_start,
    output logic           wr_start,
    output logic           rd_sw,
    output logic           rd_cur,
    output logic           strobe,
    output logic           data_ready,
    output logic           busy,
    output logic           y_wr_sw,
    output logic           y_wr_cur,
    output logic           x_wr_sw,
    output logic           x_wr_cur
);

    localparam int MAXC  = (SETUP_CYC > DRIVE_CYC) ? SETUP_CYC : DRIVE_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] DRIVE_LD = CNT_W'(DRIVE_CYC - 1);

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [X_W-1:0]   x;
        logic [Y_W-1:0]   y;
        logic [G_W-1:0]   g;
    } fsm_s;

    fsm_s q, d;
    logic cnt_done;

    assign cnt_done = (q.cnt == '0);
    assign rd_start = (q.st == ST_IDLE) && read_call && go;
    assign wr_start = (q.st == ST_WAIT_WR) && write_call && go;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (rd_start) begin
                    d.st  = ST_RD_SW;
                    d.cnt = SETUP_LD;
                    d.x   = x_in;
                    d.y   = y_in;
                    d.g   = g_in;
                end
            end
            ST_RD_SW: begin
                if (cnt_done) begin
                    d.st  = ST_RD_DRV;
                    d.cnt = DRIVE_LD;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_RD_DRV: begin
                if (cnt_done) d.st = ST_RD_END;
                else          d.cnt = q.cnt - 1'b1;
            end
            ST_RD_END: d.st = ST_WAIT_WR;
            ST_WAIT_WR: begin
                if (wr_start) begin
                    d.st  = ST_WY_SW;
                    d.cnt = SETUP_LD;
                end
            end
            ST_WY_SW: begin
                if (cnt_done) begin
                    d.st  = ST_WX_SW;
                    d.cnt = SETUP_LD;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_WX_SW: begin
                if (cnt_done) begin
                    d.st  = ST_W_DRV;
                    d.cnt = DRIVE_LD;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_W_DRV: begin
                if (cnt_done) d.st = ST_IDLE;
                else          d.cnt = q.cnt - 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign x_idx      = q.x;
    assign y_idx      = q.y;
    assign g_idx      = q.g;
    assign rd_sw      = (q.st == ST_RD_SW) || (q.st == ST_RD_DRV);
    assign rd_cur     = (q.st == ST_RD_DRV);
    assign strobe     = (q.st == ST_RD_DRV) && cnt_done;
    assign data_ready = (q.st == ST_RD_END);
    assign busy       = (q.st != ST_IDLE);
    assign y_wr_sw    = (q.st == ST_WY_SW) || (q.st == ST_WX_SW) || (q.st == ST_W_DRV);
    assign y_wr_cur   = (q.st == ST_WX_SW) || (q.st == ST_W_DRV);
    assign x_wr_sw    = (q.st == ST_WX_SW) || (q.st == ST_W_DRV);
    assign x_wr_cur   = (q.st == ST_W_DRV);

    // R9: read and write polarity never overlap
    p_polarity_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_sw && (x_wr_sw || y_wr_sw)));
    // R9: read current only after read switches
    p_rd_cur_after_sw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cur |-> $past(rd_sw));
    // R9: write currents only after their switches
    p_xw_cur_after_sw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        x_wr_cur |-> $past(x_wr_sw));
    p_yw_cur_after_sw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        y_wr_cur |-> $past(y_wr_sw));
    // R8: Y line is prepared before X line
    p_y_before_x_r8: assert property (@(posedge clk) disable iff (!rst_n)
        x_wr_sw |-> $past(y_wr_sw));
    // R6: data ready is one cycle and the block stays busy
    p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |=> (!data_ready && busy));

endmodule

// File: rtl/core_rr_sense.sv
module core_rr_sense #(
    parameter int WORD_W = 9,
    parameter int GROUPS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     strobe,
    input  logic [GROUPS-1:0]        gate,
    input  logic [GROUPS*WORD_W-1:0] sense_in,
    input  logic                     load_wd,
    input  logic                     wd_valid,
    input  logic [WORD_W-1:0]        wd_in,
    output logic [WORD_W-1:0]        lat,
    output logic [WORD_W-1:0]        wdata
);

    typedef struct packed {
        logic [WORD_W-1:0] lat;
        logic [WORD_W-1:0] wd;
    } sense_s;

    sense_s q, d;
    logic [WORD_W-1:0] hit;

    always_comb begin
        hit = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (gate[g]) hit = hit | sense_in[g*WORD_W +: WORD_W];
        end
        d = q;
        if (clr)         d.lat = '0;
        else if (strobe) d.lat = q.lat | hit;
        if (load_wd)     d.wd  = wd_valid ? wd_in : q.lat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lat   = q.lat;
    assign wdata = q.wd;

    // R5: latches empty after a clear
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lat == '0));
    // R4: latches change only on strobe or clear
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !clr) |=> $stable(lat));

endmodule

// File: rtl/core_rr_seq.sv
module core_rr_seq #(
    parameter int N_W       = 6,
    parameter int M_W       = 7,
    parameter int SG_W      = 2,
    parameter int WORD_W    = 9,
    parameter int SETUP_CYC = 2,
    parameter int DRIVE_CYC = 4,
    localparam int Y_W      = M_W - 1,
    localparam int X_N      = 2 ** N_W,
    localparam int Y_N      = 2 ** Y_W,
    localparam int GROUPS   = 2 ** SG_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     read_call,
    input  logic                     write_call,
    input  logic                     use_main,
    input  logic [M_W-1:0]           m_addr,
    input  logic [N_W-1:0]           n_addr,
    input  logic                     wr_data_valid,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic [GROUPS*WORD_W-1:0] sense_in,
    output logic                     busy,
    output logic                     data_ready,
    output logic [WORD_W-1:0]        rd_data,
    output logic [X_N-1:0]           x_src_rd,
    output logic [X_N-1:0]           x_snk_rd,
    output logic [X_N-1:0]           x_src_wr,
    output logic [X_N-1:0]           x_snk_wr,
    output logic [Y_N-1:0]           y_src_rd,
    output logic [Y_N-1:0]           y_snk_rd,
    output logic [Y_N-1:0]           y_src_wr,
    output logic [Y_N-1:0]           y_snk_wr,
    output logic                     x_ctl_rd,
    output logic                     x_ctl_wr,
    output logic                     y_ctl_rd,
    output logic                     y_ctl_wr,
    output logic                     x_cur_rd,
    output logic                     x_cur_wr,
    output logic                     y_cur_rd,
    output logic                     y_cur_wr,
    output logic [GROUPS-1:0]        sa_gate,
    output logic                     sa_strobe,
    output logic [WORD_W-1:0]        inhibit
);

    logic            go;
    logic [N_W-1:0]  x_idx;
    logic [Y_W-1:0]  y_idx;
    logic [SG_W-1:0] g_idx;
    logic            rd_start, wr_start, rd_sw, rd_cur;
    logic            y_wr_sw, y_wr_cur, x_wr_sw, x_wr_cur;
    logic [X_N-1:0]  x_oh;
    logic [Y_N-1:0]  y_oh;
    logic [WORD_W-1:0] wdata;

    assign go = use_main && !m_addr[0];

    core_rr_fsm #(
        .X_W(N_W), .Y_W(Y_W), .G_W(SG_W),
        .SETUP_CYC(SETUP_CYC), .DRIVE_CYC(DRIVE_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .read_call(read_call), .write_call(write_call), .go(go),
        .x_in(n_addr), .y_in(m_addr[M_W-1:1]), .g_in(n_addr[N_W-1 -: SG_W]),
        .x_idx(x_idx), .y_idx(y_idx), .g_idx(g_idx),
        .rd_start(rd_start), .wr_start(wr_start),
        .rd_sw(rd_sw), .rd_cur(rd_cur), .strobe(sa_strobe),
        .data_ready(data_ready), .busy(busy),
        .y_wr_sw(y_wr_sw), .y_wr_cur(y_wr_cur),
        .x_wr_sw(x_wr_sw), .x_wr_cur(x_wr_cur)
    );

    core_rr_dec #(.IDX_W(N_W))  u_xdec (.en(1'b1),   .idx(x_idx), .oh(x_oh));
    core_rr_dec #(.IDX_W(Y_W))  u_ydec (.en(1'b1),   .idx(y_idx), .oh(y_oh));
    core_rr_dec #(.IDX_W(SG_W)) u_gdec (.en(rd_cur), .idx(g_idx), .oh(sa_gate));

    core_rr_sense #(.WORD_W(WORD_W), .GROUPS(GROUPS)) u_sense (
        .clk(clk), .rst_n(rst_n),
        .clr(rd_start), .strobe(sa_strobe), .gate(sa_gate),
        .sense_in(sense_in),
        .load_wd(wr_start), .wd_valid(wr_data_valid), .wd_in(wr_data),
        .lat(rd_data), .wdata(wdata)
    );

    assign x_src_rd = x_oh & {X_N{rd_sw}};
    assign x_snk_rd = x_oh & {X_N{rd_sw}};
    assign y_src_rd = y_oh & {Y_N{rd_sw}};
    assign y_snk_rd = y_oh & {Y_N{rd_sw}};
    assign x_src_wr = x_oh & {X_N{x_wr_sw}};
    assign x_snk_wr = x_oh & {X_N{x_wr_sw}};
    assign y_src_wr = y_oh & {Y_N{y_wr_sw}};
    assign y_snk_wr = y_oh & {Y_N{y_wr_sw}};
    assign x_ctl_rd = rd_sw;
    assign y_ctl_rd = rd_sw;
    assign x_ctl_wr = x_wr_sw;
    assign y_ctl_wr = y_wr_sw;
    assign x_cur_rd = rd_cur;
    assign y_cur_rd = rd_cur;
    assign x_cur_wr = x_wr_cur;
    assign y_cur_wr = y_wr_cur;
    assign inhibit  = x_wr_cur ? ~wdata : '0;

    // R4: a strobe always has exactly one sense group gated
    p_gate_on_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sa_strobe |-> $onehot(sa_gate));
    // R2: an unqualified read call leaves the block idle
    p_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && read_call && m_addr[0]) |=> !busy);
    // R3: read switches light one line per axis
    p_rd_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        x_ctl_rd |-> ($onehot(x_src_rd) && $onehot(y_snk_rd)));

endmodule

// File: tb/core_rr_seq_bench.sv
`timescale 1ns/1ps
module core_rr_seq_bench;

    localparam int N_W = 3, M_W = 3, SG_W = 1, WORD_W = 4;
    localparam int SETUP = 2, DRV = 3;
    localparam int X_N = 8, Y_N = 4, GROUPS = 2;

    // fields: n(3) m(3) init(4) repl_valid(1) repl(4) exp_rd(4) exp_mem(4)
    localparam logic [22:0] VEC [8] = '{
        {3'd0, 3'd0, 4'hA, 1'b0, 4'h0, 4'hA, 4'hA},
        {3'd7, 3'd6, 4'h5, 1'b1, 4'h3, 4'h5, 4'h3},
        {3'd4, 3'd2, 4'hF, 1'b0, 4'h0, 4'hF, 4'hF},
        {3'd3, 3'd4, 4'h0, 1'b0, 4'h0, 4'h0, 4'h0},
        {3'd5, 3'd6, 4'h9, 1'b1, 4'hC, 4'h9, 4'hC},
        {3'd2, 3'd2, 4'h6, 1'b0, 4'h0, 4'h6, 4'h6},
        {3'd6, 3'd0, 4'h1, 1'b1, 4'h0, 4'h1, 4'h0},
        {3'd1, 3'd4, 4'hE, 1'b1, 4'hF, 4'hE, 4'hF}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, read_call, write_call, use_main, wr_data_valid;
    logic [M_W-1:0] m_addr;
    logic [N_W-1:0] n_addr;
    logic [WORD_W-1:0] wr_data;
    logic [GROUPS*WORD_W-1:0] sense_in;
    logic busy, data_ready, sa_strobe;
    logic [WORD_W-1:0] rd_data, inhibit;
    logic [X_N-1:0] x_src_rd, x_snk_rd, x_src_wr, x_snk_wr;
    logic [Y_N-1:0] y_src_rd, y_snk_rd, y_src_wr, y_snk_wr;
    logic x_ctl_rd, x_ctl_wr, y_ctl_rd, y_ctl_wr;
    logic x_cur_rd, x_cur_wr, y_cur_rd, y_cur_wr;
    logic [GROUPS-1:0] sa_gate;

    core_rr_seq #(
        .N_W(N_W), .M_W(M_W), .SG_W(SG_W), .WORD_W(WORD_W),
        .SETUP_CYC(SETUP), .DRIVE_CYC(DRV)
    ) u_core_rr_seq (.*);

    // behavioural core array
    logic [WORD_W-1:0] mem [32];
    logic [4:0] key;
    logic pre_en;
    logic [4:0] pre_key;
    logic [WORD_W-1:0] pre_val;

    always @(posedge clk) begin
        if (pre_en)                       mem[pre_key] <= pre_val;
        else if (x_cur_wr && y_cur_wr)    mem[key] <= ~inhibit;
        else if (data_ready)              mem[key] <= '0;
    end

    always_comb begin
        sense_in = '0;
        if (x_cur_rd && y_cur_rd) begin
            for (int g = 0; g < GROUPS; g++)
                sense_in[g*WORD_W +: WORD_W] = (g == int'(key[4])) ? mem[key] : 4'hF;
        end
    end

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd_phase(input logic [2:0] n, input logic [2:0] m, input logic [3:0] init, input logic [3:0] exp_rd);
        @(negedge clk);
        key = {n, m[2:1]};
        n_addr = n; m_addr = m;
        pre_en = 1; pre_key = {n, m[2:1]}; pre_val = init;
        @(negedge clk);
        pre_en = 0; read_call = 1;
        @(negedge clk);
        read_call = 0;
        chk(busy == 1, "R11 busy after read call", 32'(busy), 1);
        chk(rd_data == 0, "R5 latches cleared", 32'(rd_data), 0);
        chk(x_src_rd == X_N'(1 << n) && x_snk_rd == X_N'(1 << n), "R3 X read switches", 32'(x_src_rd), 32'(1 << n));
        chk(y_src_rd == Y_N'(1 << m[2:1]) && y_snk_rd == Y_N'(1 << m[2:1]), "R3 Y read switches", 32'(y_src_rd), 32'(1 << m[2:1]));
        chk(x_ctl_rd && y_ctl_rd && !x_cur_rd && !y_cur_rd, "R3 drivers on, currents off",
            32'({x_ctl_rd, y_ctl_rd, x_cur_rd, y_cur_rd}), 32'b1100);
        repeat (SETUP) @(negedge clk);
        chk(x_cur_rd && y_cur_rd, "R3 read current after setup", 32'({x_cur_rd, y_cur_rd}), 3);
        chk(sa_gate == GROUPS'(1 << n[2]), "R4 sense gate", 32'(sa_gate), 32'(1 << n[2]));
        chk(!sa_strobe, "R4 no early strobe", 32'(sa_strobe), 0);
        repeat (DRV - 1) @(negedge clk);
        chk(sa_strobe == 1, "R4 strobe in last drive cycle", 32'(sa_strobe), 1);
        @(negedge clk);
        chk(data_ready == 1 && !x_cur_rd, "R6 data ready", 32'({data_ready, x_cur_rd}), 2);
        chk(rd_data == exp_rd, "R4 captured word", 32'(rd_data), 32'(exp_rd));
        @(negedge clk);
        chk(!data_ready && busy, "R6 pulse, waiting", 32'({data_ready, busy}), 1);
        chk(rd_data == exp_rd, "R6 read word held", 32'(rd_data), 32'(exp_rd));
    endtask

    task automatic wr_phase(input logic [2:0] xi, input logic [1:0] yi, input logic rv, input logic [3:0] rdat, input logic [3:0] exp_mem);
        wr_data_valid = rv; wr_data = rdat; write_call = 1;
        @(negedge clk);
        write_call = 0; wr_data_valid = 0;
        chk(y_src_wr == Y_N'(1 << yi) && y_snk_wr == Y_N'(1 << yi) && y_ctl_wr, "R8 Y write switches first",
            32'(y_src_wr), 32'(1 << yi));
        chk(x_src_wr == 0 && !y_cur_wr && !x_ctl_wr, "R8 X idle during Y setup", 32'(x_src_wr), 0);
        chk(x_src_rd == 0 && y_src_rd == 0, "R9 no read polarity in write", 32'({x_src_rd, y_src_rd}), 0);
        repeat (SETUP) @(negedge clk);
        chk(x_src_wr == X_N'(1 << xi) && x_snk_wr == X_N'(1 << xi) && x_ctl_wr, "R8 X write switches",
            32'(x_src_wr), 32'(1 << xi));
        chk(y_cur_wr && !x_cur_wr, "R8 Y current before X current", 32'({y_cur_wr, x_cur_wr}), 2);
        repeat (SETUP) @(negedge clk);
        chk(x_cur_wr == 1, "R8 X write current", 32'(x_cur_wr), 1);
        chk(inhibit == ~exp_mem, "R10 inhibit pattern", 32'(inhibit), 32'(~exp_mem));
        repeat (DRV) @(negedge clk);
        chk(!busy && !x_cur_wr && inhibit == 0, "R11 idle after restore", 32'({busy, x_cur_wr}), 0);
        chk(mem[key] == exp_mem, "R10 restored word", 32'(mem[key]), 32'(exp_mem));
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; read_call = 0; write_call = 0; use_main = 1;
        wr_data_valid = 0; wr_data = 0; m_addr = 0; n_addr = 0;
        key = 0; pre_en = 0; pre_key = 0; pre_val = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !data_ready && !sa_strobe, "R1 status low", 32'({busy, data_ready, sa_strobe}), 0);
        chk(x_src_rd == 0 && x_src_wr == 0 && y_snk_rd == 0 && y_snk_wr == 0, "R1 switches off", 32'(x_src_rd), 0);
        chk(!x_cur_rd && !x_cur_wr && !y_cur_rd && !y_cur_wr && !x_ctl_rd && !y_ctl_wr, "R1 drives off", 0, 0);
        chk(sa_gate == 0 && inhibit == 0 && rd_data == 0, "R1 sense/inhibit off", 32'({sa_gate, inhibit, rd_data}), 0);

        // vector walk
        for (int i = 0; i < 8; i++) begin
            rd_phase(VEC[i][22:20], VEC[i][19:17], VEC[i][16:13], VEC[i][7:4]);
            wr_phase(VEC[i][22:20], VEC[i][19:18], VEC[i][12], VEC[i][11:8], VEC[i][3:0]);
        end

        // R2: go bit set
        @(negedge clk);
        m_addr = 3'd1; read_call = 1;
        @(negedge clk);
        read_call = 0;
        chk(!busy && x_src_rd == 0, "R2 go bit blocks read", 32'(busy), 0);
        // R2: main store not selected
        m_addr = 3'd2; use_main = 0; read_call = 1;
        @(negedge clk);
        read_call = 0; use_main = 1;
        chk(!busy && y_src_rd == 0, "R2 use_main blocks read", 32'(busy), 0);
        // R7: write call in idle
        write_call = 1;
        @(negedge clk);
        write_call = 0;
        chk(!busy && y_src_wr == 0, "R7 write in idle ignored", 32'(busy), 0);

        // R11 / R7 / R8: hold-off during a pending restore
        rd_phase(3'd2, 3'd0, 4'h7, 4'h7);
        n_addr = 3'd5; m_addr = 3'd6; read_call = 1;
        @(negedge clk);
        read_call = 0;
        chk(busy && x_src_rd == 0 && !x_ctl_rd, "R11 read held off", 32'(x_src_rd), 0);
        m_addr = 3'd1; write_call = 1;
        @(negedge clk);
        write_call = 0;
        chk(busy && y_src_wr == 0, "R7 write with go bit set ignored", 32'(y_src_wr), 0);
        m_addr = 3'd4;
        wr_phase(3'd2, 2'd0, 1'b0, 4'h0, 4'h7);
        @(negedge clk);
        chk(!busy && x_src_rd == 0, "R11 dropped read not started", 32'(busy), 0);
        @(negedge clk);
        chk(!busy, "R11 still idle", 32'(busy), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule